// File: doc/BRIEF.md
# Cycle-Shared Dual-Port Memory

This block lets two independent agents read and write one shared word array in the same system clock period. Each agent has its own address, write data, write enable and read data. Inside, a single-port array runs on a fast clock at twice the system rate. The first fast cycle of every system cycle belongs to port A, and the second belongs to port B. A one-bit slot counter steers the address, data and write-enable multiplexers. Port B's request is latched when port A's slot ends, so that it can be applied during the second slot.

The two read paths are timed differently. Port A's word is registered at the end of its slot and then holds. Port B's word comes combinationally from the array and is valid only late in the system cycle, just before the next system clock edge. Because port B is served second, it wins a same-address write collision, and its read sees a write that port A made in the same cycle. A busy flag tells the system when port A is writing the word that port B is addressing.

Both clocks come from one source with a fixed 2:1 ratio and rising edges that line up. The synchronous reset must be released just after a system clock edge, so that slot A begins on that edge.

Top module: `cs_dpram`

## Requirements
- R1: While `rst` is low, the slot alternates between port A and port B on every `clk_fast` edge. Port A is served in the fast cycle that begins at each `clk_sys` rising edge, and port B in the fast cycle that follows.
- R2: When `a_we` is 1, `a_wdata` is stored at `a_addr` during the port A slot.
- R3: When `a_we` is 0, `a_rdata` takes the word at `a_addr` at the end of the port A slot. This is the value before any port B write in the same cycle. `a_rdata` then holds, and it does not change in a cycle where `a_we` is 1.
- R4: When `b_we` is 1, `b_wdata` is stored at `b_addr` during the port B slot.
- R5: `b_rdata` is unregistered and, before the next `clk_sys` rising edge, shows the word at `b_addr`. That word includes any port A write made in the same cycle.
- R6: When both ports write the same address in one cycle, the stored word is `b_wdata`.
- R7: `busy` is 1 for a cycle exactly when `a_we` is 1 and `a_addr` equals `b_addr`; otherwise it is 0. It is valid from the end of the port A slot until the next port A slot ends.
- R8: While `rst` is high, `a_rdata` and `busy` are 0 and no write reaches the array.
- R9: Port B's inputs are sampled once, at the end of the port A slot. Any change to them later in the same cycle has no effect on that cycle's read or write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock; its rising edge starts each slot pair |
| clk_fast | input | 1 | Array clock at twice the `clk_sys` rate, with rising edges aligned to it |
| rst | input | 1 | Synchronous active-high reset (`clk_fast` domain) |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_rdata | output | DW | Port A registered read data |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_rdata | output | DW | Port B unregistered read data, valid at the end of the cycle |
| busy | output | 1 | Port A is writing the word that port B addresses |

## Verification
In a single system cycle, a port A access and a port B access can target the same word. This produces a write/write, a write/read, a read/write or a read/read clash, and a clash where port A writes also raises busy. Directed cycles force each pairing on one address. A seeded random run over a small address range makes these clashes frequent. A bench model applies port A's access and then port B's, and it predicts `a_rdata`, `b_rdata` and `busy`. These are sampled just before the next system clock edge. Separate cycles move port B's inputs after its capture point, to show that the late values are ignored.

// File: rtl/cs_dpram_pkg.sv
package cs_dpram_pkg;
  // Which port owns the array during the current fast cycle.
  typedef enum logic {
    SLOT_A = 1'b0,
    SLOT_B = 1'b1
  } slot_e;
endpackage

// File: rtl/cs_dpram_slot.sv
module cs_dpram_slot
  import cs_dpram_pkg::*;
(
  input  logic  clk_fast,
  input  logic  rst,
  output slot_e slot
);
  always_ff @(posedge clk_fast) begin
    if (rst) slot <= SLOT_A;
    else     slot <= (slot == SLOT_A) ? SLOT_B : SLOT_A;
  end

  a_r1_slot_alternates: assert property (@(posedge clk_fast) disable iff (rst)
    1'b1 |=> slot != $past(slot))
    else $error("R1: slot did not alternate");
endmodule

// File: rtl/cs_dpram_hold.sv
module cs_dpram_hold #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_fast,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          we_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          we_q
);
  always_ff @(posedge clk_fast) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      we_q   <= 1'b0;
    end else if (cap_en) begin
      addr_q <= addr_in;
      data_q <= data_in;
      we_q   <= we_in;
    end
  end

  a_r9_hold_captures: assert property (@(posedge clk_fast) disable iff (rst)
    cap_en |=> (addr_q == $past(addr_in)) && (we_q == $past(we_in)))
    else $error("R9: port B request not captured");

  a_r9_hold_stable: assert property (@(posedge clk_fast) disable iff (rst)
    !cap_en |=> $stable(addr_q) && $stable(data_q) && $stable(we_q))
    else $error("R9: port B request changed outside capture");
endmodule

// File: rtl/cs_dpram_array.sv
module cs_dpram_array #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int FULL = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  generate
    if (DEPTH == FULL) begin : g_full
      always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
      end
      assign rdata = mem[addr];
    end else begin : g_partial
      localparam logic [AW:0] LIMIT = (AW + 1)'(DEPTH);
      logic in_range;
      assign in_range = ({1'b0, addr} < LIMIT);
      always_ff @(posedge clk) begin
        if (we && in_range) mem[addr] <= wdata;
      end
      assign rdata = in_range ? mem[addr] : '0;
    end
  endgenerate
endmodule

// File: rtl/cs_dpram.sv
module cs_dpram
  import cs_dpram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 2 ** AW
) (
  input  logic          clk_sys,
  input  logic          clk_fast,
  input  logic          rst,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_we,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_we,
  output logic [DW-1:0] b_rdata,
  output logic          busy
);
  slot_e         slot;
  logic [AW-1:0] hb_addr;
  logic [DW-1:0] hb_data;
  logic          hb_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic          m_we;
  logic [DW-1:0] rd_word;

  cs_dpram_slot u_slot (
    .clk_fast (clk_fast),
    .rst      (rst),
    .slot     (slot)
  );

  cs_dpram_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk_fast (clk_fast),
    .rst      (rst),
    .cap_en   (slot == SLOT_A),
    .addr_in  (b_addr),
    .data_in  (b_wdata),
    .we_in    (b_we),
    .addr_q   (hb_addr),
    .data_q   (hb_data),
    .we_q     (hb_we)
  );

  // Slot multiplexers: live port A inputs, or the held port B request.
  always_comb begin
    if (slot == SLOT_B) begin
      m_addr = hb_addr;
      m_data = hb_data;
      m_we   = hb_we & ~rst;
    end else begin
      m_addr = a_addr;
      m_data = a_wdata;
      m_we   = a_we & ~rst;
    end
  end

  cs_dpram_array #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_array (
    .clk   (clk_fast),
    .we    (m_we),
    .addr  (m_addr),
    .wdata (m_data),
    .rdata (rd_word)
  );

  // Port A read register and collision flag, both updated as slot A ends.
  always_ff @(posedge clk_fast) begin
    if (rst) begin
      a_rdata <= '0;
      busy    <= 1'b0;
    end else if (slot == SLOT_A) begin
      busy <= a_we && (a_addr == b_addr);
      if (!a_we) a_rdata <= rd_word;
    end
  end

  // Port B sees the array directly during its slot.
  assign b_rdata = rd_word;

  a_r1_slot_aligned: assert property (@(posedge clk_sys) disable iff (rst)
    slot == SLOT_B)
    else $error("R1: slot A not aligned to system edge");

  a_r3_qa_holds_in_b: assert property (@(posedge clk_fast) disable iff (rst)
    slot == SLOT_B |=> $stable(a_rdata))
    else $error("R3: a_rdata moved outside slot A");

  a_r3_qa_holds_on_write: assert property (@(posedge clk_fast) disable iff (rst)
    (slot == SLOT_A && a_we) |=> $stable(a_rdata))
    else $error("R3: a_rdata moved on a port A write");

  a_r7_busy_stable_in_b: assert property (@(posedge clk_fast) disable iff (rst)
    slot == SLOT_B |=> $stable(busy))
    else $error("R7: busy moved outside slot A");

  a_r8_reset_clears: assert property (@(posedge clk_fast)
    rst |=> (a_rdata == '0) && !busy)
    else $error("R8: outputs not cleared by reset");
endmodule

// File: tb/cs_dpram_test.sv
module cs_dpram_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 2 ** AW;

  logic          clk_sys = 1'b0;
  logic          clk_fast = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] a_addr = '0;
  logic [DW-1:0] a_wdata = '0;
  logic          a_we = 1'b1;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic          b_we = 1'b0;
  logic [DW-1:0] a_rdata;
  logic [DW-1:0] b_rdata;
  logic          busy;

  int n_run = 0;
  int n_fail = 0;

  // Reference state
  int mem [N];
  bit known [N];
  int exp_qa = 0;

  cs_dpram #(.AW(AW), .DW(DW)) uut (
    .clk_sys (clk_sys), .clk_fast (clk_fast), .rst (rst),
    .a_addr (a_addr), .a_wdata (a_wdata), .a_we (a_we), .a_rdata (a_rdata),
    .b_addr (b_addr), .b_wdata (b_wdata), .b_we (b_we), .b_rdata (b_rdata),
    .busy (busy)
  );

  // One source: fast clock 250 MHz, system clock rises with every other fast edge.
  initial begin
    bit half = 1'b0;
    forever begin
      #2;
      clk_fast = 1'b1;
      clk_sys  = ~half;
      half     = ~half;
      #2;
      clk_fast = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One system cycle: drive, optionally disturb port B late, sample before next edge.
  task automatic cyc(input int aa, input int ad, input bit awe,
                     input int ba, input int bd, input bit bwe,
                     input bit disturb, input string tag);
    int exp_qb;
    bit qb_known;
    bit exp_busy;
    @(posedge clk_sys);
    #1;
    a_addr = AW'(aa); a_wdata = DW'(ad); a_we = awe;
    b_addr = AW'(ba); b_wdata = DW'(bd); b_we = bwe;
    exp_busy = awe && (aa == ba);
    if (awe) begin
      mem[aa] = ad;
      known[aa] = 1'b1;
    end else if (known[aa]) begin
      exp_qa = mem[aa];
    end
    exp_qb = mem[ba];
    qb_known = known[ba];
    #4;
    if (disturb) begin
      // R9: late changes to port B must be ignored this cycle
      b_addr = AW'(ba + 1); b_wdata = ~DW'(bd); b_we = ~bwe;
    end
    #2;
    check({tag, " R3 a_rdata"}, int'(a_rdata), exp_qa);
    if (qb_known) check({tag, " R5 b_rdata"}, int'(b_rdata), exp_qb);
    check({tag, " R7 busy"}, int'(busy), int'(exp_busy));
    if (bwe) begin
      mem[ba] = bd;
      known[ba] = 1'b1;
    end
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mem[i] = 0;
      known[i] = 1'b0;
    end
    repeat (4) @(posedge clk_sys);
    #3;
    check("R8 reset a_rdata", int'(a_rdata), 0);
    check("R8 reset busy", int'(busy), 0);
    // Release just after a system edge; this cycle writes word 0 with 0.
    @(posedge clk_sys);
    #1;
    rst = 1'b0;
    mem[0] = 0;
    known[0] = 1'b1;

    // R2 / R4: fill the array from both ports
    for (int i = 0; i < N / 2; i++)
      cyc(i, 8'h10 + i, 1'b1, i + N / 2, 8'h80 + i, 1'b1, 1'b0, "R2 R4 fill");
    // R3 / R5 / R1: read back crosswise
    for (int i = 0; i < N; i++)
      cyc(i, 0, 1'b0, N - 1 - i, 0, 1'b0, 1'b0, "R1 R3 R5 read");
    // R6: write/write collision, port B wins
    cyc(3, 8'hAA, 1'b1, 3, 8'h55, 1'b1, 1'b0, "R6 R7 ww");
    cyc(3, 0, 1'b0, 3, 0, 1'b0, 1'b0, "R6 readback");
    // R5 / R7: port A writes what port B reads
    cyc(5, 8'h77, 1'b1, 5, 0, 1'b0, 1'b0, "R5 R7 wr");
    // R3: port A read while port B writes same word
    cyc(6, 0, 1'b0, 6, 8'h12, 1'b1, 1'b0, "R3 rw");
    cyc(6, 0, 1'b0, 6, 0, 1'b0, 1'b0, "R4 rr");
    // R9: late port B changes ignored
    cyc(1, 0, 1'b0, 9, 8'h3C, 1'b1, 1'b1, "R9 late write");
    cyc(9, 0, 1'b0, 10, 0, 1'b0, 1'b0, "R9 check");
    cyc(2, 8'h44, 1'b1, 11, 0, 1'b0, 1'b1, "R9 late read");
    cyc(11, 0, 1'b0, 12, 0, 1'b0, 1'b0, "R9 check2");
    // Mixed traffic on a narrow address range for frequent clashes
    for (int k = 0; k < 200; k++) begin
      int r;
      r = int'($urandom);
      cyc(r & 3, (r >> 4) & 255, r[12], (r >> 2) & 3, (r >> 16) & 255, r[13],
          1'b0, "R6 R7 mixed");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule